// File: doc/BRIEF.md
# Indexed Configuration Port with Unlock Key

This block gives software access to a bank of indexed configuration registers through two byte-wide I/O addresses: an index address and a data address one above it. The base address is chosen by a strap input, either 0x2E or 0x4E. Until an unlock key is written, the port is closed. In that state only the key decoder listens, and every read returns 0xFF.

Once the port is open, software writes a register number to the index address. It then reads or writes that register through the data address. The block keeps these registers itself:

- the index register;
- a logical-device select register;
- a fixed chip identifier;
- one activate bit per logical device.

Accesses to any other index go out to the selected logical device's register bank, together with the latched index. The bank answers a read in the same bus cycle.

The host side uses plain strobes and has no back-pressure. An access completes in the clock cycle in which its read or write strobe is high, and the read data is valid in that same cycle. The forwarded device strobes follow the same rule, so the device banks must not stall.

Top module: `siocfg_port`

## Requirements
- R1: The index address equals the base, and the data address equals the base plus one. The base is 0x2E when `strap_alt` is 0 and 0x4E when it is 1. An access to any other address changes nothing, forwards nothing and reads 0xFF.
- R2: After reset:
  - the port is closed (`cfg_open` = 0);
  - the index is 0x00;
  - the device select is 0x00;
  - all activate bits are 0.
- R3: Two consecutive index-address writes of 0x87 open the port, and `cfg_open` rises on the clock after the second write. An index write of any other value while the port is closed returns the key decoder to its start, so that the next 0x87 counts as the first one.
- R4: An index-address write of 0xAA while the port is open closes it on the next clock. The index register keeps its previous value.
- R5: While the port is open, index 0x07 reads and writes the full 8-bit logical-device select. Its value appears on `dev_sel` from the clock after the write.
- R6: Index 0x20 reads back the `CHIP_ID` parameter. Data writes to index 0x20 have no effect.
- R7: Index 0x30 holds the activate bit in data bit 0 for the selected device. The bit for device n drives `dev_active[n]`, and the other data bits read 0. When the select is `NUM_DEV` or more, writes are dropped and reads return 0.
- R8: While the port is closed:
  - data writes change no state;
  - reads of either address return 0xFF;
  - `dev_wr` and `dev_rd` stay low;
  - the index does not change.
- R9: While the port is open, a data access to any index other than 0x07, 0x20 or 0x30 raises `dev_wr` or `dev_rd` in the same cycle, with `dev_idx` equal to the latched index and `dev_wdata` equal to the bus data. The read data on `bus_rdata` is `dev_rdata` in that same cycle.
- R10: While the port is open, a read of the index address returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| strap_alt | input | 1 | Base address select: 0 selects 0x2E, 1 selects 0x4E |
| bus_addr | input | ADDR_W | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| cfg_open | output | 1 | Port unlocked |
| dev_sel | output | 8 | Selected logical device number |
| dev_idx | output | 8 | Latched register index |
| dev_wr | output | 1 | Forwarded data write to the selected device bank |
| dev_rd | output | 1 | Forwarded data read from the selected device bank |
| dev_wdata | output | 8 | Forwarded write data |
| dev_rdata | input | 8 | Read data returned by the selected device bank |
| dev_active | output | NUM_DEV | Activate bit of each logical device |

## Verification
The bench builds the port with `NUM_DEV` set to 4 and `CHIP_ID` set to 0xC3. The small device count makes select values at and beyond the last device easy to reach, so the dropped activate writes and the zero readback of R7 can be checked. The identifier is not the default value, so a hard-wired identifier would be caught. Because the strap is an input, the bench switches it during the run to cover both base addresses. It also checks that the address belonging to the inactive base is ignored.

// File: rtl/siocfg_pkg.sv
`timescale 1ns/1ps
package siocfg_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2
  } lock_st_e;

  localparam logic [7:0] KEY_ENTER  = 8'h87;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] RD_IDLE    = 8'hFF;
endpackage

// File: rtl/siocfg_addr_dec.sv
`timescale 1ns/1ps
// Decodes the two port addresses from the strap-selected base.
module siocfg_addr_dec #(
  parameter int ADDR_W  = 16,
  parameter int BASE_LO = 'h2E,
  parameter int BASE_HI = 'h4E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  localparam logic [ADDR_W-1:0] LO_IDX = ADDR_W'(BASE_LO);
  localparam logic [ADDR_W-1:0] LO_DAT = ADDR_W'(BASE_LO + 1);
  localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(BASE_HI);
  localparam logic [ADDR_W-1:0] HI_DAT = ADDR_W'(BASE_HI + 1);

  logic hit_idx, hit_dat;

  always_comb begin
    if (strap_alt) begin
      hit_idx = (addr == HI_IDX);
      hit_dat = (addr == HI_DAT);
    end else begin
      hit_idx = (addr == LO_IDX);
      hit_dat = (addr == LO_DAT);
    end
  end

  assign idx_wr = wr & hit_idx;
  assign idx_rd = rd & hit_idx;
  assign dat_wr = wr & hit_dat;
  assign dat_rd = rd & hit_dat;
endmodule

// File: rtl/siocfg_key_fsm.sv
`timescale 1ns/1ps
// Lock state machine: two enter keys open the port, the exit key closes it.
module siocfg_key_fsm
  import siocfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic       idx_load
);
  lock_st_e st, st_nx;

  always_comb begin
    st_nx    = st;
    idx_load = 1'b0;
    if (idx_wr) begin
      case (st)
        ST_LOCKED: st_nx = (wdata == KEY_ENTER) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   st_nx = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (wdata == KEY_EXIT) st_nx = ST_LOCKED;
          else                   idx_load = 1'b1;
        end
        default:   st_nx = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_LOCKED;
    else        st <= st_nx;
  end

  assign open = (st == ST_OPEN);
endmodule

// File: rtl/siocfg_regs.sv
`timescale 1ns/1ps
// Index, device select, activate bits, read mux and forwarding to device banks.
module siocfg_regs
  import siocfg_pkg::*;
#(
  parameter int          NUM_DEV = 16,
  parameter logic [7:0]  CHIP_ID = 8'h52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               open,
  input  logic               idx_load,
  input  logic               idx_rd,
  input  logic               dat_wr,
  input  logic               dat_rd,
  input  logic [7:0]         wdata,
  input  logic [7:0]         dev_rdata,
  output logic [7:0]         rdata,
  output logic [7:0]         index,
  output logic [7:0]         ldn,
  output logic [NUM_DEV-1:0] act,
  output logic               dev_wr,
  output logic               dev_rd
);
  logic is_ldn, is_id, is_act, is_fwd;
  logic wr_ok, rd_ok, act_sel;
  logic [NUM_DEV-1:0] sel_hit;

  assign is_ldn = (index == IDX_LDN);
  assign is_id  = (index == IDX_CHIPID);
  assign is_act = (index == IDX_ACT);
  assign is_fwd = !(is_ldn || is_id || is_act);
  assign wr_ok  = open & dat_wr;
  assign rd_ok  = open & dat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        index <= 8'h00;
    else if (idx_load) index <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ldn <= 8'h00;
    else if (wr_ok && is_ldn)  ldn <= wdata;
  end

  // One activate flop per logical device.
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_act
    assign sel_hit[g] = (ldn == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             act[g] <= 1'b0;
      else if (wr_ok && is_act && sel_hit[g]) act[g] <= wdata[0];
    end
  end

  assign act_sel = |(act & sel_hit);

  always_comb begin
    rdata = RD_IDLE;
    if (open && idx_rd) begin
      rdata = index;
    end else if (rd_ok) begin
      if (is_ldn)      rdata = ldn;
      else if (is_id)  rdata = CHIP_ID;
      else if (is_act) rdata = {7'b0, act_sel};
      else             rdata = dev_rdata;
    end
  end

  assign dev_wr = wr_ok & is_fwd;
  assign dev_rd = rd_ok & is_fwd;
endmodule

// File: rtl/siocfg_port.sv
`timescale 1ns/1ps
module siocfg_port #(
  parameter int         ADDR_W  = 16,
  parameter int         BASE_LO = 'h2E,
  parameter int         BASE_HI = 'h4E,
  parameter int         NUM_DEV = 16,
  parameter logic [7:0] CHIP_ID = 8'h52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_alt,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               cfg_open,
  output logic [7:0]         dev_sel,
  output logic [7:0]         dev_idx,
  output logic               dev_wr,
  output logic               dev_rd,
  output logic [7:0]         dev_wdata,
  input  logic [7:0]         dev_rdata,
  output logic [NUM_DEV-1:0] dev_active
);
  logic idx_wr, idx_rd, dat_wr, dat_rd, idx_load;

  siocfg_addr_dec #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_dec (
    .strap_alt (strap_alt),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .idx_wr    (idx_wr),
    .idx_rd    (idx_rd),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd)
  );

  siocfg_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (bus_wdata),
    .open     (cfg_open),
    .idx_load (idx_load)
  );

  siocfg_regs #(.NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .open      (cfg_open),
    .idx_load  (idx_load),
    .idx_rd    (idx_rd),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .wdata     (bus_wdata),
    .dev_rdata (dev_rdata),
    .rdata     (bus_rdata),
    .index     (dev_idx),
    .ldn       (dev_sel),
    .act       (dev_active),
    .dev_wr    (dev_wr),
    .dev_rd    (dev_rd)
  );

  assign dev_wdata = bus_wdata;
endmodule

// File: rtl/siocfg_port_chk.sv
`timescale 1ns/1ps
module siocfg_port_chk #(
  parameter int         ADDR_W  = 16,
  parameter int         BASE_LO = 'h2E,
  parameter int         BASE_HI = 'h4E,
  parameter int         NUM_DEV = 16,
  parameter logic [7:0] CHIP_ID = 8'h52
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strap_alt,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [7:0]         bus_wdata,
  input logic [7:0]         bus_rdata,
  input logic               cfg_open,
  input logic [7:0]         dev_sel,
  input logic [7:0]         dev_idx,
  input logic               dev_wr,
  input logic               dev_rd,
  input logic [NUM_DEV-1:0] dev_active
);
  logic [ADDR_W-1:0] base;
  logic idx_w, dat_w, dat_r;

  assign base  = strap_alt ? ADDR_W'(BASE_HI) : ADDR_W'(BASE_LO);
  assign idx_w = bus_wr && (bus_addr == base);
  assign dat_w = bus_wr && (bus_addr == base + ADDR_W'(1));
  assign dat_r = bus_rd && (bus_addr == base + ADDR_W'(1));

  a_r3_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(idx_w && bus_wdata == 8'h87));

  a_r4_exit_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_w && bus_wdata == 8'hAA) |=> !cfg_open);

  a_r5_select_written: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && dat_w && dev_idx == 8'h07) |=> dev_sel == $past(bus_wdata));

  a_r6_chip_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && dat_r && dev_idx == 8'h20) |-> bus_rdata == CHIP_ID);

  a_r8_no_forward_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (!dev_wr && !dev_rd));

  a_r8_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && bus_rd) |-> bus_rdata == 8'hFF);

  a_r8_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(dev_idx));

  a_r8_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_sel) && $stable(dev_active)));
endmodule

bind siocfg_port siocfg_port_chk #(
  .ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI),
  .NUM_DEV(NUM_DEV), .CHIP_ID(CHIP_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cfg_open(cfg_open), .dev_sel(dev_sel), .dev_idx(dev_idx),
  .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_active(dev_active)
);

// File: tb/siocfg_port_bench.sv
`timescale 1ns/1ps
module siocfg_port_bench;
  localparam int         NDEV = 4;
  localparam logic [7:0] ID   = 8'hC3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, strap_alt = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, dev_sel, dev_idx, dev_wdata, dev_rdata;
  logic        cfg_open, dev_wr, dev_rd;
  logic [NDEV-1:0] dev_active;

  siocfg_port #(.NUM_DEV(NDEV), .CHIP_ID(ID)) u_siocfg_port (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_open(cfg_open), .dev_sel(dev_sel), .dev_idx(dev_idx), .dev_wr(dev_wr),
    .dev_rd(dev_rd), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .dev_active(dev_active)
  );

  // Device bank stand-in: answers with a value derived from index and select.
  assign dev_rdata = dev_idx ^ dev_sel ^ 8'h5A;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  // Reference model state
  int m_st = 0, m_idx = 0, m_ldn = 0;
  logic [NDEV-1:0] m_act = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Registered outputs compared against the model on every clock.
  always @(negedge clk) if (!done) begin
    chk(cfg_open == (m_st == 2), "R3", cfg_open, m_st == 2);
    chk(dev_sel == 8'(m_ldn), "R5", dev_sel, m_ldn);
    chk(dev_active == m_act, "R7", dev_active, m_act);
  end

  task automatic op(bit wr, bit rd, int addr, int d, string req);
    int  base, er;
    bit  hi, hd, efwd;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = 16'(addr); bus_wdata = 8'(d);
    #1;
    base = strap_alt ? 'h4E : 'h2E;
    hi   = (addr == base);
    hd   = (addr == base + 1);
    efwd = hd && m_st == 2 && m_idx != 'h07 && m_idx != 'h20 && m_idx != 'h30;
    er   = 'hFF;
    if (rd && m_st == 2) begin
      if (hi) er = m_idx;
      else if (hd) begin
        if (m_idx == 'h07)      er = m_ldn;
        else if (m_idx == 'h20) er = ID;
        else if (m_idx == 'h30) er = (m_ldn < NDEV) ? int'(m_act[m_ldn]) : 0;
        else                    er = (m_idx ^ m_ldn ^ 'h5A) & 'hFF;
      end
    end
    if (rd) chk(bus_rdata == 8'(er), req, bus_rdata, er);
    chk(dev_wr == (wr && efwd), req, dev_wr, wr && efwd);
    chk(dev_rd == (rd && efwd), req, dev_rd, rd && efwd);
    if (efwd) chk(dev_idx == 8'(m_idx) && (!wr || dev_wdata == 8'(d)), req, dev_idx, m_idx);
    @(posedge clk);
    #1;
    if (wr && hi) begin
      if (m_st == 2) begin
        if (d == 'hAA) m_st = 0;
        else           m_idx = d;
      end else if (d == 'h87) m_st = m_st + 1;
      else                    m_st = 0;
    end else if (wr && hd && m_st == 2) begin
      if (m_idx == 'h07) m_ldn = d;
      else if (m_idx == 'h30 && m_ldn < NDEV) m_act[m_ldn] = d[0];
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset values
    chk(cfg_open == 1'b0, "R2", cfg_open, 0);
    chk(dev_idx == 8'h00, "R2", dev_idx, 0);
    chk(dev_sel == 8'h00 && dev_active == '0, "R2", dev_sel, 0);
    rst_n = 1'b1;
    // R8: closed port ignores data writes and reads 0xFF
    op(1, 0, 'h2F, 'h05, "R8");
    op(0, 1, 'h2F, 0, "R8");
    op(0, 1, 'h2E, 0, "R8");
    // R3: broken key sequence, then a single key
    op(1, 0, 'h2E, 'h87, "R3");
    op(1, 0, 'h2E, 'h55, "R3");
    op(1, 0, 'h2E, 'h87, "R3");
    chk(cfg_open == 1'b0, "R3", cfg_open, 0);
    op(1, 0, 'h2E, 'h87, "R3");
    chk(cfg_open == 1'b1, "R3", cfg_open, 1);
    // R10: index readback (key writes left it at 0)
    op(0, 1, 'h2E, 0, "R10");
    // R5: device select
    op(1, 0, 'h2E, 'h07, "R5");
    op(1, 0, 'h2F, 'h02, "R5");
    op(0, 1, 'h2F, 0, "R5");
    // R6: identifier, writes ignored
    op(1, 0, 'h2E, 'h20, "R6");
    op(0, 1, 'h2F, 0, "R6");
    op(1, 0, 'h2F, 'h00, "R6");
    op(0, 1, 'h2F, 0, "R6");
    // R7: activate bits, in range and out of range
    op(1, 0, 'h2E, 'h30, "R7");
    op(1, 0, 'h2F, 'hFF, "R7");
    op(0, 1, 'h2F, 0, "R7");
    chk(dev_active == 4'b0100, "R7", dev_active, 4'b0100);
    op(1, 0, 'h2E, 'h07, "R7");
    op(1, 0, 'h2F, 'h06, "R7");
    op(1, 0, 'h2E, 'h30, "R7");
    op(1, 0, 'h2F, 'h01, "R7");
    op(0, 1, 'h2F, 0, "R7");
    chk(dev_active == 4'b0100, "R7", dev_active, 4'b0100);
    op(1, 0, 'h2E, 'h07, "R7");
    op(1, 0, 'h2F, 'h03, "R7");
    op(1, 0, 'h2E, 'h30, "R7");
    op(1, 0, 'h2F, 'h01, "R7");
    op(1, 0, 'h2F, 'h00, "R7");
    op(1, 0, 'h2F, 'h01, "R7");
    // R9: forwarding
    op(1, 0, 'h2E, 'h41, "R9");
    op(1, 0, 'h2F, 'h3C, "R9");
    op(0, 1, 'h2F, 0, "R9");
    op(1, 0, 'h2E, 'hF5, "R9");
    op(0, 1, 'h2F, 0, "R9");
    // R1: wrong-base addresses, then the strap switch
    op(1, 0, 'h4E, 'h07, "R1");
    op(0, 1, 'h4F, 0, "R1");
    op(0, 1, 'h30, 0, "R1");
    strap_alt = 1'b1;
    op(0, 1, 'h4E, 0, "R1");
    op(1, 0, 'h2E, 'h07, "R1");
    op(0, 1, 'h2F, 0, "R1");
    op(1, 0, 'h4E, 'h41, "R1");
    op(0, 1, 'h4F, 0, "R1");
    // R4: exit key closes, index kept
    op(1, 0, 'h4E, 'hAA, "R4");
    chk(cfg_open == 1'b0, "R4", cfg_open, 0);
    op(0, 1, 'h4E, 0, "R8");
    op(0, 1, 'h4F, 0, "R8");
    op(1, 0, 'h4F, 'h11, "R8");
    op(1, 0, 'h4E, 'h87, "R4");
    op(1, 0, 'h4E, 'h87, "R4");
    op(0, 1, 'h4E, 0, "R4");
    chk(dev_idx == 8'h41, "R4", dev_idx, 'h41);
    repeat (2) @(posedge clk);
    summary();
  end
endmodule